// File: doc/BRIEF.md
# Paged Stack Pointer Unit

This block forms stack memory addresses for a small 8-bit processor core. It keeps an 8-bit stack pointer that always names the low address byte of the slot the next push will fill. It places that byte on memory page 0 or page 1, and the page is picked at run time by one bit of a memory-mapped processor mode register. The instruction sequencer hands the block push and pop requests: single bytes for the accumulator or the status register, and two-byte return addresses for calls and interrupt entry. The block drives the address, write data, write enable and read enable of a synchronous RAM port. Pop data comes back one cycle after the read address, which matches the RAM's registered output.

Every RAM access takes one clock and raises `done` in that clock. A two-byte return address takes two back-to-back accesses. While the second access runs, `ready` is low and new requests are dropped. The pointer can be copied to and from an index register through a transfer port. Its value after reset carries no meaning, so software loads it before first use.

Top module: `stack_addr_unit`

## Requirements
- R1: After reset the block makes no RAM access (`ram_we`=0, `ram_re`=0, `done`=0), `ready` is 1 and the stack page is 0.
- R2: A push writes its byte at address {page, SP} in the cycle the request is accepted, with `ram_we`=1 and `done`=1. SP is one less from the next cycle on.
- R3: A pop reads address {page, SP+1} in the cycle the request is accepted, with `ram_re`=1 and `done`=1. SP is one more from the next cycle on. The byte appears on `pop_data` with `pop_valid`=1 exactly one cycle later.
- R4: `req_op` encodings: 0 pushes `acc_in`, 1 pops into the accumulator, 2 pushes `psr_in`, 3 pops into the status register, 4 pushes the return address, 5 pops the return address. Codes 6 and 7 make no access.
- R5: A return-address push writes `ret_in[15:8]` at {page, SP} in the first cycle. In the second cycle it writes `ret_in[7:0]` at the new {page, SP}, with `ready`=0.
- R6: A return-address pop reads the low byte at {page, SP+1} and then the high byte at the next address up, with `ready`=0 in the second cycle. `ret_out` is {high, low}, with `ret_valid`=1 one cycle after the second read.
- R7: SP steps modulo 256 and never leaves the selected page. A push at SP=0x00 leaves 0xFF. A pop at SP=0xFF reads offset 0x00 of the same page.
- R8: A write with `mode_addr`=0x00FB sets the page from `mode_wdata` bit 2 (0 gives high address byte 0x00, 1 gives 0x01). The new page applies to accesses after that cycle. Writes to any other address do not change the page, and no mode write changes SP.
- R9: `sp_load` loads `sp_load_val` into SP for the next cycle, and `sp_out` always shows SP. A load in a cycle that makes a RAM access is ignored.
- R10: A request presented while `ready`=0 is dropped: it makes no access and changes neither SP nor the result stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Stack request present |
| req_op | input | 3 | Request code (see R4) |
| acc_in | input | 8 | Accumulator byte to push |
| psr_in | input | 8 | Status byte to push |
| ret_in | input | 16 | Return address to push |
| ready | output | 1 | Block accepts a request this cycle |
| done | output | 1 | A RAM access happens this cycle |
| sp_load | input | 1 | Load SP from transfer port |
| sp_load_val | input | 8 | Value to load into SP |
| sp_out | output | 8 | Current SP for transfer out |
| mode_we | input | 1 | Mode register bus write strobe |
| mode_addr | input | 16 | Mode register bus write address |
| mode_wdata | input | 8 | Mode register bus write data |
| ram_addr | output | 16 | Stack RAM address |
| ram_we | output | 1 | Stack RAM write enable |
| ram_re | output | 1 | Stack RAM read enable |
| ram_wdata | output | 8 | Stack RAM write data |
| ram_rdata | input | 8 | Stack RAM read data, one cycle after address |
| pop_valid | output | 1 | Single-byte pop result valid |
| pop_data | output | 8 | Single-byte pop result |
| ret_valid | output | 1 | Return-address pop result valid |
| ret_out | output | 16 | Popped return address |

## Verification
The bench pushes at SP=0x00 and pops at SP=0xFF. A design that let the pointer carry into the high byte would put those accesses on the wrong page. It checks both byte orders of a two-byte return address, since swapping them returns a byte-swapped address or clobbers the neighbouring slot. It moves the stack to page 1 and back, writes to an address next to the mode register, and checks that the pointer survives, which catches a loose address decode or a page write that disturbs SP. It also presents a request and a pointer load while the block is busy and expects both to be dropped.

// File: rtl/stk_pkg.sv
package stk_pkg;
  parameter int unsigned SP_W = 8;
  parameter int unsigned AW   = 16;
  parameter int unsigned DW   = 8;

  typedef enum logic [2:0] {
    OP_PUSH_ACC = 3'd0,
    OP_POP_ACC  = 3'd1,
    OP_PUSH_PSR = 3'd2,
    OP_POP_PSR  = 3'd3,
    OP_PUSH_RET = 3'd4,
    OP_POP_RET  = 3'd5
  } stk_op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH_LO, ST_POP_HI} stk_state_e;
  typedef enum logic [1:0] {RD_NONE, RD_BYTE, RD_RET_LO, RD_RET_HI} rd_kind_e;

  function automatic logic [SP_W-1:0] sp_after_push(input logic [SP_W-1:0] sp);
    return sp - 1'b1;
  endfunction

  function automatic logic [SP_W-1:0] sp_after_pop(input logic [SP_W-1:0] sp);
    return sp + 1'b1;
  endfunction

  function automatic logic [AW-1:0] stack_addr(input logic page, input logic [SP_W-1:0] sp);
    return {{(AW-SP_W-1){1'b0}}, page, sp};
  endfunction
endpackage

// File: rtl/stk_mode_reg.sv
module stk_mode_reg #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter logic [15:0] MODE_ADDR = 16'h00FB,
  parameter int unsigned PAGE_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              page_q
);
  logic hit;
  assign hit = wr_en && (wr_addr == MODE_ADDR[ADDR_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   page_q <= 1'b0;
    else if (hit) page_q <= wr_data[PAGE_BIT];
  end
endmodule

// File: rtl/stk_pointer.sv
module stk_pointer
  import stk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_down,
  input  logic            step_up,
  input  logic            load,
  input  logic [SP_W-1:0] load_val,
  output logic [SP_W-1:0] sp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sp_q <= '0;
    else if (step_down) sp_q <= sp_after_push(sp_q);
    else if (step_up)   sp_q <= sp_after_pop(sp_q);
    else if (load)      sp_q <= load_val;
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [DW-1:0]   acc_in,
  input  logic [DW-1:0]   psr_in,
  input  logic [2*DW-1:0] ret_in,
  input  logic            page,
  input  logic [SP_W-1:0] sp,
  output logic [AW-1:0]   ram_addr,
  output logic            ram_we,
  output logic            ram_re,
  output logic [DW-1:0]   ram_wdata,
  output logic            ready,
  output rd_kind_e        rd_next,
  output logic            push_lo_phase,
  output logic            pop_hi_phase
);
  stk_state_e state_q, state_d;
  logic [DW-1:0] hold_q;
  logic          hold_load;
  logic          fire;

  assign ready         = (state_q == ST_IDLE);
  assign fire          = req_valid && ready;
  assign push_lo_phase = (state_q == ST_PUSH_LO);
  assign pop_hi_phase  = (state_q == ST_POP_HI);

  always_comb begin
    state_d   = state_q;
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_wdata = '0;
    rd_next   = RD_NONE;
    hold_load = 1'b0;
    case (state_q)
      ST_IDLE: if (fire) begin
        case (stk_op_e'(req_op))
          OP_PUSH_ACC: begin ram_we = 1'b1; ram_wdata = acc_in; end
          OP_PUSH_PSR: begin ram_we = 1'b1; ram_wdata = psr_in; end
          OP_PUSH_RET: begin
            ram_we    = 1'b1;
            ram_wdata = ret_in[2*DW-1:DW];
            hold_load = 1'b1;
            state_d   = ST_PUSH_LO;
          end
          OP_POP_ACC, OP_POP_PSR: begin ram_re = 1'b1; rd_next = RD_BYTE; end
          OP_POP_RET: begin
            ram_re  = 1'b1;
            rd_next = RD_RET_LO;
            state_d = ST_POP_HI;
          end
          default: ;
        endcase
      end
      ST_PUSH_LO: begin
        ram_we    = 1'b1;
        ram_wdata = hold_q;
        state_d   = ST_IDLE;
      end
      ST_POP_HI: begin
        ram_re  = 1'b1;
        rd_next = RD_RET_HI;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ram_addr = ram_re ? stack_addr(page, sp_after_pop(sp)) : stack_addr(page, sp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (hold_load) hold_q <= ret_in[DW-1:0];
    end
  end
endmodule

// File: rtl/stack_addr_unit.sv
module stack_addr_unit
  import stk_pkg::*;
#(
  parameter logic [15:0] MODE_ADDR = 16'h00FB,
  parameter int unsigned PAGE_BIT  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [7:0]      acc_in,
  input  logic [7:0]      psr_in,
  input  logic [15:0]     ret_in,
  output logic            ready,
  output logic            done,
  input  logic            sp_load,
  input  logic [7:0]      sp_load_val,
  output logic [7:0]      sp_out,
  input  logic            mode_we,
  input  logic [15:0]     mode_addr,
  input  logic [7:0]      mode_wdata,
  output logic [15:0]     ram_addr,
  output logic            ram_we,
  output logic            ram_re,
  output logic [7:0]      ram_wdata,
  input  logic [7:0]      ram_rdata,
  output logic            pop_valid,
  output logic [7:0]      pop_data,
  output logic            ret_valid,
  output logic [15:0]     ret_out
);
  logic          page;
  logic          access;
  logic          push_lo_phase;
  logic          pop_hi_phase;
  rd_kind_e      rd_next, rd_kind_q;
  logic [DW-1:0] ret_lo_q;

  stk_mode_reg #(
    .ADDR_W(AW), .DATA_W(DW), .MODE_ADDR(MODE_ADDR), .PAGE_BIT(PAGE_BIT)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(mode_we), .wr_addr(mode_addr),
    .wr_data(mode_wdata), .page_q(page)
  );

  stk_pointer u_sp (
    .clk(clk), .rst_n(rst_n), .step_down(ram_we), .step_up(ram_re),
    .load(sp_load && !access), .load_val(sp_load_val), .sp_q(sp_out)
  );

  stk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .acc_in(acc_in), .psr_in(psr_in), .ret_in(ret_in), .page(page), .sp(sp_out),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata),
    .ready(ready), .rd_next(rd_next), .push_lo_phase(push_lo_phase),
    .pop_hi_phase(pop_hi_phase)
  );

  assign access = ram_we || ram_re;
  assign done   = access;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_kind_q <= RD_NONE;
      ret_lo_q  <= '0;
    end else begin
      rd_kind_q <= rd_next;
      if (rd_kind_q == RD_RET_LO) ret_lo_q <= ram_rdata;
    end
  end

  assign pop_valid = (rd_kind_q == RD_BYTE);
  assign pop_data  = ram_rdata;
  assign ret_valid = (rd_kind_q == RD_RET_HI);
  assign ret_out   = {ram_rdata, ret_lo_q};
endmodule

// File: rtl/stk_checker.sv
module stk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ram_we,
  input logic        ram_re,
  input logic [15:0] ram_addr,
  input logic [7:0]  sp_out,
  input logic        ready,
  input logic        pop_valid,
  input logic        ret_valid,
  input logic        push_lo_phase,
  input logic        pop_hi_phase
);
  assert_one_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));

  assert_push_steps_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (sp_out == 8'($past(sp_out) - 8'd1)));

  assert_pop_steps_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |=> (sp_out == 8'($past(sp_out) + 8'd1)));

  assert_pop_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> $past(ram_re));

  assert_ret_push_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_lo_phase |-> (ram_we && !ready));

  assert_ret_pop_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(pop_hi_phase));

  assert_page_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> (ram_addr[15:9] == 7'd0));

  assert_busy_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);
endmodule

bind stack_addr_unit stk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
  .sp_out(sp_out), .ready(ready), .pop_valid(pop_valid), .ret_valid(ret_valid),
  .push_lo_phase(push_lo_phase), .pop_hi_phase(pop_hi_phase)
);

// File: tb/stack_addr_unit_tb_top.sv
`timescale 1ns/1ps
module stack_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd7;
  logic [7:0]  acc_in = '0, psr_in = '0, sp_load_val = '0, mode_wdata = '0;
  logic [15:0] ret_in = '0, mode_addr = '0;
  logic        sp_load = 1'b0, mode_we = 1'b0;
  logic        ready, done, ram_we, ram_re, pop_valid, ret_valid;
  logic [7:0]  sp_out, ram_wdata, ram_rdata, pop_data;
  logic [15:0] ram_addr, ret_out;

  always #2.5 clk = ~clk;

  stack_addr_unit dut_i (.*);

  logic [7:0] mem [0:511];
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr[8:0]] <= ram_wdata;
    ram_rdata <= mem[ram_addr[8:0]];
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0]  sp_m;
  logic        page_m = 1'b0;
  logic [7:0]  byte_q[$];
  logic [15:0] ret_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] addr_of(logic pg, logic [7:0] off);
    return 16'(pg) * 16'd256 + 16'(off);
  endfunction

  // Scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (pop_valid) begin
      if (byte_q.size() == 0) check("R3 unexpected pop", 1, 0);
      else check("R3 pop data", pop_data, byte_q.pop_front());
    end
    if (ret_valid) begin
      if (ret_q.size() == 0) check("R6 unexpected ret", 1, 0);
      else check("R6 ret address", ret_out, ret_q.pop_front());
    end
  end

  task automatic release_req();
    @(posedge clk); #1;
    req_valid = 1'b0; req_op = 3'd7; sp_load = 1'b0; mode_we = 1'b0;
  endtask

  task automatic push_byte(bit is_psr, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = is_psr ? 3'd2 : 3'd0;
    if (is_psr) psr_in = d; else acc_in = d;
    #1;
    check("R2 write enable", ram_we, 1);
    check("R2 done", done, 1);
    check("R2 push address", ram_addr, addr_of(page_m, sp_m));
    check("R4 push data", ram_wdata, d);
    sp_m = 8'((int'(sp_m) + 255) % 256);
    release_req();
  endtask

  task automatic pop_byte(bit is_psr, logic [7:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_op = is_psr ? 3'd3 : 3'd1;
    #1;
    sp_m = 8'((int'(sp_m) + 1) % 256);
    check("R3 read enable", ram_re, 1);
    check("R3 pop address", ram_addr, addr_of(page_m, sp_m));
    byte_q.push_back(exp);
    release_req();
  endtask

  task automatic push_ret(logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd4; ret_in = a;
    #1;
    check("R5 high byte first", ram_wdata, a[15:8]);
    check("R5 first address", ram_addr, addr_of(page_m, sp_m));
    sp_m = sp_m - 8'd1;
    @(posedge clk); #1;
    req_op = 3'd1; ret_in = 16'h0;  // R10: request while busy must be dropped
    sp_load = 1'b1; sp_load_val = 8'h33; // R9: load during access ignored
    @(negedge clk); #1;
    check("R5 second write", {ram_we, ram_re, ready}, 3'b100);
    check("R5 low byte second", ram_wdata, a[7:0]);
    check("R5 second address", ram_addr, addr_of(page_m, sp_m));
    sp_m = sp_m - 8'd1;
    release_req();
  endtask

  task automatic pop_ret(logic [15:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd5;
    #1;
    sp_m = sp_m + 8'd1;
    check("R6 low byte address", ram_addr, addr_of(page_m, sp_m));
    @(posedge clk); #1;
    req_op = 3'd0; acc_in = 8'hEE; // R10: push while busy must be dropped
    @(negedge clk); #1;
    sp_m = sp_m + 8'd1;
    check("R6 second read", {ram_we, ram_re, ready}, 3'b010);
    check("R6 high byte address", ram_addr, addr_of(page_m, sp_m));
    ret_q.push_back(exp);
    release_req();
  endtask

  task automatic load_sp(logic [7:0] v);
    @(negedge clk);
    sp_load = 1'b1; sp_load_val = v;
    release_req();
    sp_m = v;
    @(negedge clk); #1;
    check("R9 sp transfer", sp_out, v);
  endtask

  task automatic write_mode(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    mode_we = 1'b1; mode_addr = a; mode_wdata = d;
    release_req();
    if (a == 16'h00FB) page_m = d[2];
    @(negedge clk); #1;
    check("R8 sp unchanged by mode write", sp_out, sp_m);
  endtask

  task automatic idle_check_sp(string req);
    repeat (2) @(negedge clk);
    #1 check(req, sp_out, sp_m);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset no access", {ram_we, ram_re, done}, 3'b000);
    check("R1 reset ready", ready, 1);
    rst_n = 1'b1;
    load_sp(8'h80);
    check("R1 reset page 0", ram_addr[15:8], 8'h00);

    push_byte(0, 8'h11);
    push_byte(1, 8'h22);
    pop_byte(1, 8'h22);
    pop_byte(0, 8'h11);
    idle_check_sp("R3 sp restored");

    push_ret(16'hABCD);
    idle_check_sp("R10 busy request and R9 busy load dropped");
    pop_ret(16'hABCD);
    idle_check_sp("R6 sp restored");

    // R4: codes 6 and 7 make no access
    @(negedge clk); req_valid = 1'b1; req_op = 3'd6; #1;
    check("R4 unused code no access", {ram_we, ram_re, done}, 3'b000);
    release_req();

    // R7 wrap in page 0
    load_sp(8'h00);
    push_byte(0, 8'h55);
    check("R7 wrap down", sp_m, 8'hFF);
    idle_check_sp("R7 sp after wrap");
    pop_byte(0, 8'h55);
    load_sp(8'hFF);
    pop_byte(0, 8'h55);

    // R8 page selection
    load_sp(8'h80);
    write_mode(16'h00FB, 8'h04);
    push_byte(0, 8'h77);
    write_mode(16'h00FA, 8'h00);   // neighbouring address: page stays 1
    pop_byte(0, 8'h77);
    push_ret(16'h1234);
    pop_ret(16'h1234);
    write_mode(16'h00FB, 8'hFB);   // bit 2 clear: back to page 0
    push_byte(1, 8'h9A);
    pop_byte(1, 8'h9A);
    load_sp(8'hFF);
    write_mode(16'h00FB, 8'h04);
    pop_byte(0, 8'h00);            // R7 wrap up inside page 1: offset 0x00

    repeat (4) @(negedge clk);
    check("scoreboard drained", byte_q.size() + ret_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule